// File: doc/BRIEF.md
# Serial Timing Event Transmitter

This block puts 8-bit timing event codes onto one serial line using a Manchester-style code at 10 Mbit/s. The line level toggles at the start of every bit cell. A one bit also toggles the line in the middle of its cell, and a zero bit does not. Each event goes out as a frame of ten cells: a start cell that always carries a one, the eight event bits with the most significant bit first, and an odd parity bit. With eight event bits there are 256 distinct codes.

When no event is waiting, the line keeps sending encoded zeros. A receiver's phase-locked loop therefore always sees a cell-rate edge and stays locked. Because the start cell is a one, it marks the beginning of a frame in that idle stream.

Events enter through a valid/ready handshake. An internal divider turns the system clock into half-cell ticks. With a 100 MHz system clock and `HALF_DIV` = 5, one cell lasts 100 ns. An accepted event goes out from the next cell boundary. `evt_ready` stays low until the parity cell of that frame has finished.

Top module: `evt_serializer`

## Requirements
- R1: When no event is pending, every cell on `line_o` encodes a zero: the line toggles at the cell boundary and holds its level through the middle of the cell.
- R2: Each half cell lasts exactly `HALF_DIV` system clocks. The line toggles at every cell boundary. A one cell toggles again at mid-cell, and a zero cell does not.
- R3: A frame is ten consecutive cells in this order: a start cell carrying 1, then the eight event bits with bit 7 first and bit 0 last, then the parity cell.
- R4: The parity cell makes the number of ones across the eight event bits and the parity bit odd.
- R5: An event is accepted on a clock edge where both `evt_valid` and `evt_ready` are high. `evt_ready` is low in the cycle after acceptance.
- R6: After acceptance, `evt_ready` stays low until the parity cell of that frame has finished. It returns high between 10 and 11 cell times after acceptance. While `evt_ready` is low, `evt_valid` and `evt_data` have no effect.
- R7: At least one idle zero cell separates two consecutive frames.
- R8: While `rst_n` is low, `line_o` is 0 and `evt_ready` is 1. Any event that is pending or partly sent is discarded, so no frame follows the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_data | input | 8 | Event code to send |
| evt_valid | input | 1 | Event code is offered |
| evt_ready | output | 1 | Transmitter can accept an event |
| line_o | output | 1 | Encoded serial line |

## Verification
The bench decodes `line_o` itself. It samples every half cell, treats any cell whose two halves differ as a one, and flags any cell boundary where the line did not toggle. This catches a design that drops the boundary edge or puts a mid-cell edge on a zero. Event codes made of all zeros, all ones and mixed patterns expose a wrong bit order, a wrong parity sense or a missing start cell; any of these shows up as a corrupted code or a parity failure. Holding `evt_valid` high with a different code during a frame would produce an extra frame, or a frame carrying the wrong code, if `evt_ready` released early. A reset in the middle of a frame would be followed by a stray frame if the pending event were kept. Sending events back to back shows whether the frames run together with no idle cell between them.

// File: rtl/evt_serializer.sv
module evt_serializer #(
  parameter int EVT_W    = 8,
  parameter int HALF_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_data,
  input  logic             evt_valid,
  output logic             evt_ready,
  output logic             line_o
);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SR_W   = EVT_W + 1;
  localparam int LEFT_W = $clog2(SR_W + 1);

  logic [DIV_W-1:0]  div_q;
  logic              half_tick, boundary;
  logic              phase_q, line_q, cur_bit_q;
  logic              pend_q, in_frame_q;
  logic [EVT_W-1:0]  hold_q;
  logic [SR_W-1:0]   sr_q;
  logic [LEFT_W-1:0] left_q;

  assign half_tick = (div_q == DIV_W'(HALF_DIV - 1));
  assign boundary  = half_tick & ~phase_q;
  assign evt_ready = ~pend_q & ~in_frame_q;
  assign line_o    = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (half_tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (evt_valid && evt_ready) begin
      pend_q <= 1'b1;
      hold_q <= evt_data;
    end else if (boundary && left_q == '0) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bit_q  <= 1'b0;
      sr_q       <= '0;
      left_q     <= '0;
      in_frame_q <= 1'b0;
    end else if (boundary) begin
      if (left_q != '0) begin
        cur_bit_q <= sr_q[SR_W-1];
        sr_q      <= sr_q << 1;
        left_q    <= left_q - 1'b1;
      end else if (pend_q) begin
        cur_bit_q  <= 1'b1;
        sr_q       <= {hold_q, ~^hold_q};
        left_q     <= LEFT_W'(SR_W);
        in_frame_q <= 1'b1;
      end else begin
        cur_bit_q  <= 1'b0;
        in_frame_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= 1'b0;
    else if (boundary || (half_tick && cur_bit_q))
      line_q <= ~line_q;
  end
endmodule

// File: rtl/evt_serializer_chk.sv
module evt_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_valid,
  input logic evt_ready,
  input logic line_o,
  input logic half_tick,
  input logic phase_q,
  input logic cur_bit_q,
  input logic in_frame_q
);
  p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready |=> !evt_ready);

  p_line_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(line_o));

  p_boundary_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick && !phase_q |=> line_o != $past(line_o));

  p_zero_no_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick && phase_q && !cur_bit_q |=> $stable(line_o));

  p_ready_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ready) |-> $past(half_tick) && !$past(phase_q));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready && half_tick && !phase_q |=> !cur_bit_q);

  p_start_is_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame_q) |-> cur_bit_q);
endmodule

bind evt_serializer evt_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .line_o     (line_o),
  .half_tick  (half_tick),
  .phase_q    (phase_q),
  .cur_bit_q  (cur_bit_q),
  .in_frame_q (in_frame_q)
);

// File: tb/evt_serializer_tb.sv
module evt_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HD   = 4;
  localparam int CELL = 2 * HD;
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h0F, 8'h07, 8'h80, 8'h01, 8'h3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] evt_data = '0;
  logic evt_valid = 1'b0;
  logic evt_ready, line_o;

  int checks = 0;
  int fails = 0;

  evt_serializer #(.EVT_W(8), .HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_data(evt_data), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .line_o(line_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // line decoder
  logic rxbits [0:4095];
  int nbits = 0;
  int bnd_err = 0;
  int cnt = 0;
  logic started = 1'b0, prev = 1'b0, h0 = 1'b0, have_h0 = 1'b0, last_h1 = 1'b0, have_last = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      started = 1'b0; prev = 1'b0; have_h0 = 1'b0; have_last = 1'b0; cnt = 0;
    end else if (!started) begin
      if (line_o != prev) begin started = 1'b1; cnt = 1; end
      prev = line_o;
    end else begin
      if (cnt % HD == HD / 2) begin
        if (!have_h0) begin
          h0 = line_o; have_h0 = 1'b1;
          if (have_last && h0 == last_h1) bnd_err++;
        end else begin
          if (nbits < 4096) begin rxbits[nbits] = h0 ^ line_o; nbits++; end
          last_h1 = line_o; have_last = 1'b1; have_h0 = 1'b0;
        end
      end
      cnt++;
    end
  end

  logic [7:0] fr_data [0:63];
  logic       fr_par  [0:63];
  int         fr_gap  [0:63];
  int         nfr;

  task automatic parse();
    int i = 0;
    int zeros = 0;
    nfr = 0;
    while (i < nbits) begin
      if (rxbits[i] == 1'b0) begin
        zeros++; i++;
      end else begin
        if (i + 10 > nbits || nfr >= 64) break;
        for (int b = 0; b < 8; b++) fr_data[nfr][7-b] = rxbits[i+1+b];
        fr_par[nfr] = rxbits[i+9];
        fr_gap[nfr] = zeros;
        zeros = 0; nfr++; i += 10;
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cells(input int n);
    repeat (n * CELL) @(negedge clk);
  endtask

  task automatic send_evt(input logic [7:0] b, input bit measure);
    int k = 0;
    while (!evt_ready && k < 40 * CELL) begin @(negedge clk); k++; end
    evt_data = b; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    chk(evt_ready == 1'b0, "R5 ready low after accept", evt_ready, 0);
    k = 1;
    while (!evt_ready && k < 40 * CELL) begin @(negedge clk); k++; end
    if (measure)
      chk(k >= 10 * CELL + 2 && k <= 11 * CELL + 1, "R6 ready low duration", k, 10 * CELL + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_o == 1'b0, "R8 line low in reset", line_o, 0);
    chk(evt_ready == 1'b1, "R8 ready high in reset", evt_ready, 1);
    rst_n = 1'b1;

    // R1 idle stream
    wait_cells(30);
    parse();
    chk(nbits >= 25, "R1 idle cells decoded", nbits, 25);
    chk(nfr == 0, "R1 idle carries no frame", nfr, 0);
    chk(bnd_err == 0, "R2 boundary edges in idle", bnd_err, 0);

    // table of event codes, sent back to back
    nbits = 0;
    for (int v = 0; v < NVEC; v++) send_evt(VEC[v], 1'b1);
    wait_cells(3);
    parse();
    chk(nfr == NVEC, "R3 frame count", nfr, NVEC);
    for (int v = 0; v < NVEC && v < nfr; v++) begin
      chk(fr_data[v] == VEC[v], "R3 event code", fr_data[v], VEC[v]);
      chk(($countones({fr_data[v], fr_par[v]}) % 2) == 1, "R4 odd parity", fr_par[v], ~^VEC[v]);
      if (v > 0) chk(fr_gap[v] >= 1, "R7 idle gap between frames", fr_gap[v], 1);
    end
    chk(bnd_err == 0, "R2 boundary edges in frames", bnd_err, 0);

    // R6 valid held while busy with a different code
    nbits = 0;
    evt_data = 8'h5A; evt_valid = 1'b1;
    @(negedge clk);
    evt_data = 8'hC3;
    for (int k = 0; k < 40 * CELL && !evt_ready; k++) @(negedge clk);
    evt_valid = 1'b0;
    wait_cells(4);
    parse();
    chk(nfr == 1, "R6 busy valid ignored count", nfr, 1);
    chk(nfr >= 1 && fr_data[0] == 8'h5A, "R6 busy data ignored", fr_data[0], 8'h5A);

    // R8 reset during a frame
    send_evt(8'h96, 1'b0);
    wait_cells(4);
    evt_data = 8'h33; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    wait_cells(3);
    rst_n = 1'b0;
    @(negedge clk);
    chk(line_o == 1'b0, "R8 line low after mid-frame reset", line_o, 0);
    chk(evt_ready == 1'b1, "R8 ready high after mid-frame reset", evt_ready, 1);
    nbits = 0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_cells(25);
    parse();
    chk(nfr == 0, "R8 pending event discarded", nfr, 0);
    chk(nbits >= 20, "R1 idle resumes after reset", nbits, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule